// File: doc/BRIEF.md
# LCD Byte Write Handshake Engine

This block moves one byte at a time from an upstream sequencer to a character display controller. The controller reports its state on a busy line and takes work through a request strobe. The sequencer offers a byte with a one-cycle start pulse. The engine then waits until the display reports idle and places the byte on the data bus. One cycle later it raises the request. The display shows that it has taken the byte by raising busy. The engine then withdraws the request and signals completion with a single-cycle done pulse.

The sequencer decides what bytes to send. A complete character, for example, is five transfers in a row: a command byte, two coordinates and two code bytes. Each wait on busy is limited by a configurable cycle budget. When the budget runs out, the engine drops the request, raises a sticky error flag and goes back to idle. All outputs come from registers. The asynchronous active-low reset is released synchronously inside the block.

Top module: `lcd_wr_hs`

## Requirements
- R1: After a start, the data bus is not loaded while busy is sampled 1. The bus takes the captured byte on the first clock edge at which busy is sampled 0, and it changes at no other time except reset.
- R2: The request rises exactly one cycle after the bus is loaded. The bus holds its value while the request is high and through the done pulse.
- R3: With the request high, it stays high as long as busy is sampled 0. On the edge that samples busy at 1, the request falls, done is high for exactly one cycle and ready returns to 1.
- R4: Ready is 1 only in idle. A start sampled while ready is 1 captures the data input on that edge. Ready drops on that same edge, so a later change of the data input does not affect the transfer.
- R5: A start that arrives while ready is 0 is ignored. The byte in flight is unchanged, and no second transfer follows the done pulse.
- R6: Each wait on busy samples busy at most TMO_CYC times. If the expected level is still absent at the last sample, the request is forced low, the error flag is set, ready returns to 1 and done stays 0. If the level appears exactly at the last sample, the transfer succeeds.
- R7: The error flag stays set until the next accepted start, and that start clears it.
- R8: While the reset input is low, the outputs are request 0, bus 0x00, done 0, error 0 and ready 1, even in the middle of a transfer. After release the engine accepts a new transfer normally.
- R9: Transfers issued back to back deliver every byte in order. The check uses the five-byte character sequence 0xF0, X, Y, zone code, position code, each with its own busy timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that asks for a byte transfer |
| din | input | 8 | Byte to send, captured together with start |
| ready | output | 1 | High while idle and able to accept a start |
| done | output | 1 | One-cycle pulse when a transfer completes |
| err | output | 1 | Sticky timeout flag, cleared by the next accepted start |
| lcd_busy | input | 1 | Busy line from the display controller |
| lcd_data | output | 8 | Data bus to the display controller |
| lcd_req | output | 1 | Request strobe to the display controller |

## Verification
The directed scenarios focus on ordering. Busy is held high before a transfer, to catch a design that drives the bus early or raises the request before the data is set up. Busy is held low after the request, to catch a design that drops the request too early or pulses done without acceptance. Each timeout is placed exactly at its limit and at one sample beyond it, which exposes off-by-one errors in the wait budget. A start is injected during a transfer, and reset is pulled mid-transfer. A wrong design would corrupt the byte in flight, launch a phantom second transfer, or leave the request stuck high.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_LOW  = 2'd1,
    ST_SETUP     = 2'd2,
    ST_WAIT_HIGH = 2'd3
  } lcd_st_e;
endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lcd_wr_tmo.sv
module lcd_wr_tmo #(
  parameter int TMO_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expire
);
  localparam int CW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                     cnt_d = '0;
    else if (en && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = en && (cnt_q == LAST);
endmodule

// File: rtl/lcd_wr_fsm.sv
module lcd_wr_fsm
  import lcd_wr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  input  logic expire,
  output logic cap,
  output logic drive,
  output logic raise,
  output logic finish,
  output logic fail,
  output logic in_wait,
  output logic moving,
  output logic ready_q
);
  lcd_st_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    cap    = 1'b0;
    drive  = 1'b0;
    raise  = 1'b0;
    finish = 1'b0;
    fail   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d = ST_WAIT_LOW;
          cap  = 1'b1;
        end
      end
      ST_WAIT_LOW: begin
        if (!busy) begin
          st_d  = ST_SETUP;
          drive = 1'b1;
        end else if (expire) begin
          st_d = ST_IDLE;
          fail = 1'b1;
        end
      end
      ST_SETUP: begin
        st_d  = ST_WAIT_HIGH;
        raise = 1'b1;
      end
      ST_WAIT_HIGH: begin
        if (busy) begin
          st_d   = ST_IDLE;
          finish = 1'b1;
        end else if (expire) begin
          st_d = ST_IDLE;
          fail = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign in_wait = (st_q == ST_WAIT_LOW) || (st_q == ST_WAIT_HIGH);
  assign moving  = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ready_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      ready_q <= (st_d == ST_IDLE);
    end
  end
endmodule

// File: rtl/lcd_wr_dp.sv
module lcd_wr_dp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          cap,
  input  logic          drive,
  input  logic          raise,
  input  logic          finish,
  input  logic          fail,
  output logic [DW-1:0] bus_q,
  output logic          req_q,
  output logic          done_q,
  output logic          err_q
);
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (cap) hold_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_q <= '0;
    else if (drive) bus_q <= hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               req_q <= 1'b0;
    else if (raise)           req_q <= 1'b1;
    else if (finish || fail)  req_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err_q <= 1'b0;
    else if (fail) err_q <= 1'b1;
    else if (cap)  err_q <= 1'b0;
  end
endmodule

// File: rtl/lcd_wr_hs.sv
module lcd_wr_hs #(
  parameter int DW      = 8,
  parameter int TMO_CYC = 1024,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] din,
  output logic          ready,
  output logic          done,
  output logic          err,
  input  logic          lcd_busy,
  output logic [DW-1:0] lcd_data,
  output logic          lcd_req
);
  logic rst_i_n;
  logic cap, drive, raise, finish, fail, in_wait, moving, expire;

  lcd_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  lcd_wr_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .start(start), .busy(lcd_busy),
    .expire(expire), .cap(cap), .drive(drive), .raise(raise),
    .finish(finish), .fail(fail), .in_wait(in_wait), .moving(moving),
    .ready_q(ready)
  );

  lcd_wr_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_i_n), .clr(moving || !in_wait),
    .en(in_wait), .expire(expire)
  );

  lcd_wr_dp #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_i_n), .din(din), .cap(cap), .drive(drive),
    .raise(raise), .finish(finish), .fail(fail), .bus_q(lcd_data),
    .req_q(lcd_req), .done_q(done), .err_q(err)
  );
endmodule

// File: rtl/lcd_wr_hs_chk.sv
module lcd_wr_hs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          done,
  input logic          err,
  input logic          lcd_busy,
  input logic [DW-1:0] lcd_data,
  input logic          lcd_req
);
  assert_data_after_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lcd_data) |-> !$past(lcd_busy));

  assert_req_after_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_req) |-> $stable(lcd_data));

  assert_data_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_req && $past(lcd_req)) |-> $stable(lcd_data));

  assert_done_on_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(lcd_req) && $past(lcd_busy) && ready));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !lcd_req);

  assert_timeout_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!done && !lcd_req && ready));
endmodule

bind lcd_wr_hs lcd_wr_hs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .done(done), .err(err),
  .lcd_busy(lcd_busy), .lcd_data(lcd_data), .lcd_req(lcd_req)
);

// File: tb/sim_lcd_wr_hs.sv
`timescale 1ns/1ps
module sim_lcd_wr_hs;
  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst_n, start, lcd_busy;
  logic [7:0] din;
  logic ready, done, err, lcd_req;
  logic [7:0] lcd_data;
  int n_chk = 0;
  int n_err = 0;
  logic [7:0] last_bus = 8'h00;

  always #4 clk = ~clk;

  lcd_wr_hs #(.DW(8), .TMO_CYC(TMO), .SYNC_ST(2)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din), .ready(ready),
    .done(done), .err(err), .lcd_busy(lcd_busy), .lcd_data(lcd_data),
    .lcd_req(lcd_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Full transfer: nlow busy-high samples before idle, nhigh busy-low samples before accept
  task automatic do_xfer(input logic [7:0] d, input int nlow, input int nhigh, input bit poke);
    lcd_busy = (nlow > 0);
    start = 1'b1; din = d;
    step();
    start = 1'b0; din = ~d;
    chk("R4 ready low after start", ready, 0);
    chk("R1 bus not driven before idle", lcd_data, last_bus);
    for (int i = 0; i < nlow; i++) begin
      step();
      chk("R1 bus held while busy", lcd_data, last_bus);
      chk("R1 no req while busy", lcd_req, 0);
    end
    lcd_busy = 1'b0;
    step();
    chk("R1 bus loaded after idle", lcd_data, d);
    chk("R2 req still low in setup", lcd_req, 0);
    step();
    chk("R2 req rises after data", lcd_req, 1);
    for (int i = 0; i < nhigh; i++) begin
      if (poke && i == 0) begin start = 1'b1; din = 8'h5A; end
      step();
      start = 1'b0;
      chk("R3 req held until accept", lcd_req, 1);
      chk("R3 no done before accept", done, 0);
      chk("R2 data stable under req", lcd_data, d);
    end
    lcd_busy = 1'b1;
    step();
    chk("R3 req drops on accept", lcd_req, 0);
    chk("R3 done pulse", done, 1);
    chk("R3 ready back", ready, 1);
    chk("R2 data kept at done", lcd_data, d);
    lcd_busy = 1'b0;
    step();
    chk("R3 done single cycle", done, 0);
    last_bus = d;
  endtask

  task automatic t_reset();
    chk("R8 reset req", lcd_req, 0);
    chk("R8 reset bus", lcd_data, 0);
    chk("R8 reset ready", ready, 1);
    chk("R8 reset done", done, 0);
    chk("R8 reset err", err, 0);
  endtask

  task automatic t_ignore_start();
    do_xfer(8'h3C, 0, 3, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R5 no phantom transfer ready", ready, 1);
      chk("R5 no phantom req", lcd_req, 0);
      chk("R5 byte not replaced", lcd_data, 8'h3C);
    end
  endtask

  task automatic t_tmo_low();
    lcd_busy = 1'b1; start = 1'b1; din = 8'h77;
    step();
    start = 1'b0;
    for (int i = 0; i < TMO - 1; i++) begin
      step();
      chk("R6 still waiting", ready, 0);
      chk("R6 no err yet", err, 0);
    end
    step();
    chk("R6 timeout err", err, 1);
    chk("R6 timeout ready", ready, 1);
    chk("R6 timeout req low", lcd_req, 0);
    chk("R6 timeout no done", done, 0);
    chk("R1 bus untouched on timeout", lcd_data, last_bus);
    lcd_busy = 1'b0;
    step();
    chk("R7 err sticky", err, 1);
    chk("R6 stays idle", lcd_req, 0);
  endtask

  task automatic t_tmo_high();
    lcd_busy = 1'b0; start = 1'b1; din = 8'h99;
    step();
    start = 1'b0;
    chk("R7 err cleared by start", err, 0);
    step();
    step();
    chk("R2 req up", lcd_req, 1);
    for (int i = 0; i < TMO - 1; i++) begin
      step();
      chk("R6 req held in budget", lcd_req, 1);
    end
    step();
    chk("R6 req forced low", lcd_req, 0);
    chk("R6 err on ack timeout", err, 1);
    chk("R6 no done on timeout", done, 0);
    last_bus = 8'h99;
  endtask

  task automatic t_reset_mid();
    lcd_busy = 1'b0; start = 1'b1; din = 8'hC3;
    step();
    start = 1'b0;
    step();
    step();
    chk("R8 pre-reset req up", lcd_req, 1);
    rst_n = 1'b0;
    #1;
    chk("R8 async req clear", lcd_req, 0);
    chk("R8 async bus clear", lcd_data, 0);
    chk("R8 async ready", ready, 1);
    chk("R8 async err clear", err, 0);
    step();
    rst_n = 1'b1;
    step(); step(); step();
    last_bus = 8'h00;
    do_xfer(8'h4E, 1, 1, 1'b0);
    chk("R8 transfer after reset", lcd_data, 8'h4E);
  endtask

  task automatic t_char_seq();
    logic [7:0] seq [5];
    seq[0] = 8'hF0; seq[1] = 8'h12; seq[2] = 8'h05; seq[3] = 8'hB0; seq[4] = 8'hA1;
    for (int k = 0; k < 5; k++) begin
      do_xfer(seq[k], k % 3, (k * 2) % 5, 1'b0);
      chk("R9 sequence byte", lcd_data, seq[k]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; din = 8'h00; lcd_busy = 1'b0;
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step(); step(); step();
    t_reset();
    do_xfer(8'hA5, 0, 0, 1'b0);
    do_xfer(8'h81, 3, 2, 1'b0);
    do_xfer(8'h6D, TMO - 1, TMO - 1, 1'b0);
    chk("R6 limit-edge success no err", err, 0);
    t_ignore_start();
    t_tmo_low();
    t_tmo_high();
    t_char_seq();
    t_reset_mid();
    finish_run();
  end
endmodule